// File: doc/BRIEF.md
# Serial Port Buffer Status Tracker

This block keeps the occupancy state of a serial transceiver's transmit and receive buffering and presents it as a 32-bit read-only status word. The transmit side counts queued frames, which software writes over the bus and the shifter retires as each frame finishes. The receive side stores arriving frames in a small buffer, with one extra holding slot that stands for the receive shift register. Software drains that storage one frame per read strobe.

Single-cycle command strobes turn each control flag on or off: receiver enable, transmitter enable, master mode, receive blocking and transmitter tristate. A threshold-select input picks when the transmit level flag reports room. Each incoming frame either goes into the receive storage or is dropped. A frame dropped because blocking was on raises a one-cycle drop pulse. A frame dropped because no slot was free raises a one-cycle overflow pulse.

Top module: `serial_buf_status`

## Requirements
- R1: The status word is laid out as bit 0 receiver enabled, bit 1 transmitter enabled, bit 2 master mode, bit 3 receive blocking, bit 4 transmitter tristated, bit 5 transmit complete, bit 6 transmit level, bit 7 receive data valid, bit 8 receive full. Bits 31:9 are always 0.
- R2: After reset the status word reads 0x40: only the transmit level flag is 1.
- R3: Receive data valid is 1 while the receive storage holds at least one frame. Receive full is 1 while it holds at least RX_DEPTH frames. Each flag drops as soon as its condition stops holding.
- R4: While receive full is 1, exactly one more frame is accepted (the shift-register slot). That frame is later read out after the buffered ones.
- R5: A frame that completes while all RX_DEPTH+1 slots are occupied, with no read in the same cycle, is dropped, and rx_ovf is 1 for the cycle that follows.
- R6: A frame completes while the blocking flag (its value before that clock edge) is 1. Such a frame is not stored, and rx_blk_drop is 1 for the following cycle. A blocking command given in the same cycle as the frame does not affect that frame.
- R7: With half_thr = 0 the transmit level flag is 1 only when the transmit buffer is empty. With half_thr = 1 it is 1 when the buffer holds at most TX_DEPTH/2 frames.
- R8: Transmit complete becomes 1 when tx_sent retires the last queued frame. Any tx_wr clears it, and a write takes priority over a retire in the same cycle.
- R9: A tx_wr while the transmit buffer holds TX_DEPTH frames is not stored. A tx_sent while the buffer is empty changes nothing.
- R10: A read of empty receive storage returns 0 on rd_data and changes no state.
- R11: Receiver enable, transmitter enable, master mode and blocking each have a set strobe and a clear strobe. When both strobes of a pair are high in one cycle, the flag is cleared.
- R12: The tristate flag is set by cmd_tri_en and cleared by cmd_tri_dis. A transmitter-enable strobe also clears it, and a clear wins over a set in the same cycle.
- R13: rd_data shows the oldest stored frame (or 0 when empty). A read pops it, and a read and an arrival in the same cycle are both honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rx_en | input | 1 | Set receiver enable |
| cmd_rx_dis | input | 1 | Clear receiver enable |
| cmd_tx_en | input | 1 | Set transmitter enable (also clears tristate) |
| cmd_tx_dis | input | 1 | Clear transmitter enable |
| cmd_mst_en | input | 1 | Set master mode |
| cmd_mst_dis | input | 1 | Clear master mode |
| cmd_blk_en | input | 1 | Set receive blocking |
| cmd_blk_dis | input | 1 | Clear receive blocking |
| cmd_tri_en | input | 1 | Set transmitter tristate |
| cmd_tri_dis | input | 1 | Clear transmitter tristate |
| tx_wr | input | 1 | Bus write into the transmit buffer |
| tx_sent | input | 1 | Shifter finished sending one frame |
| half_thr | input | 1 | Transmit level threshold: 0 empty, 1 half-full |
| rx_done | input | 1 | Shifter finished receiving one frame |
| rx_data | input | DATA_W | Received frame payload |
| rx_rd | input | 1 | Bus read that pops the receive storage |
| rd_data | output | DATA_W | Oldest stored frame, 0 when empty |
| status | output | 32 | Status word |
| rx_ovf | output | 1 | One-cycle pulse: frame lost to overflow |
| rx_blk_drop | output | 1 | One-cycle pulse: frame discarded by blocking |

## Verification
The bench builds the block with the default sizes: two transmit entries, two receive entries and 8-bit frames. At these depths, three frames fill every receive slot and a fourth overflows. Two writes reach the half-full and full transmit boundaries. Every corner is therefore a handful of cycles apart, and a long random stretch crosses these boundaries many times, including same-cycle reads with arrivals and set/clear collisions.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int STATUS_W = 32;

    // status bit positions (software decodes these)
    localparam int ST_RXEN   = 0;
    localparam int ST_TXEN   = 1;
    localparam int ST_MST    = 2;
    localparam int ST_BLK    = 3;
    localparam int ST_TRI    = 4;
    localparam int ST_TXC    = 5;
    localparam int ST_TXBL   = 6;
    localparam int ST_DATAV  = 7;
    localparam int ST_RXFULL = 8;

    // index of each command-controlled flag inside the flag bank
    typedef enum logic [2:0] {
        FL_RXEN = 3'd0,
        FL_TXEN = 3'd1,
        FL_MST  = 3'd2,
        FL_BLK  = 3'd3,
        FL_TRI  = 3'd4
    } flag_idx_e;

    localparam int N_FLAGS = 5;

endpackage

// File: rtl/sbs_flag_bank.sv
module sbs_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    typedef struct packed {
        logic [N-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N; k++) begin
            if (clr_i[k]) begin
                st_d.flags[k] = 1'b0;
            end else if (set_i[k]) begin
                st_d.flags[k] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flags;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R11 / R12: clear strobe dominates
        a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i[g] |=> !flag_o[g]);
        a_r11_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[g] && !clr_i[g]) |=> flag_o[g]);
    end

endmodule

// File: rtl/sbs_tx_track.sv
module sbs_tx_track #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic sent_i,
    input  logic thr_i,
    output logic level_o,
    output logic done_o
);

    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tx_t;

    tx_t st_d, st_q;
    logic accept, retire;

    always_comb begin
        st_d   = st_q;
        accept = wr_i && (st_q.cnt < CW'(DEPTH));
        retire = sent_i && (st_q.cnt != '0);
        if (accept && !retire) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (retire && !accept) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_i) begin
            st_d.done = 1'b0;
        end else if (retire && st_q.cnt == CW'(1)) begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (thr_i) begin
            level_o = (st_q.cnt <= CW'(HALF));
        end else begin
            level_o = (st_q.cnt == '0);
        end
    end

    assign done_o = st_q.done;

    // R9: a write into a full buffer leaves the occupancy unchanged
    a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !sent_i && st_q.cnt == CW'(DEPTH)) |=> st_q.cnt == CW'(DEPTH));
    // R9: retire on an empty buffer does nothing
    a_r9_empty_retire_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_i && !wr_i && st_q.cnt == '0) |=> (st_q.cnt == '0 && $stable(done_o)));
    // R8: any write clears transmit complete
    a_r8_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !done_o);
    // R8: transmit complete only rises after a retire
    a_r8_done_after_sent: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(sent_i));

endmodule

// File: rtl/sbs_rx_queue.sv
module sbs_rx_queue #(
    parameter int DEPTH  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              blk_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              datav_o,
    output logic              full_o,
    output logic              ovf_o,
    output logic              dsc_o
);

    // DEPTH buffer entries plus one slot standing for the shift register
    localparam int CAP = DEPTH + 1;
    localparam int CW  = $clog2(CAP + 1);

    typedef struct packed {
        logic [CAP-1:0][DATA_W-1:0] mem;
        logic [CW-1:0]              cnt;
        logic                       ovf;
        logic                       dsc;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.dsc = 1'b0;
        // pop first so a same-cycle arrival can reuse the freed slot
        if (rd_i && st_q.cnt != '0) begin
            for (int i = 0; i < CAP - 1; i++) begin
                st_d.mem[i] = st_q.mem[i+1];
            end
            st_d.mem[CAP-1] = '0;
            st_d.cnt        = st_q.cnt - 1'b1;
        end
        if (frame_i) begin
            if (blk_i) begin
                st_d.dsc = 1'b1;
            end else if (st_d.cnt < CW'(CAP)) begin
                for (int i = 0; i < CAP; i++) begin
                    if (CW'(i) == st_d.cnt) begin
                        st_d.mem[i] = data_i;
                    end
                end
                st_d.cnt = st_d.cnt + 1'b1;
            end else begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = (st_q.cnt != '0) ? st_q.mem[0] : '0;
    assign datav_o   = (st_q.cnt != '0);
    assign full_o    = (st_q.cnt >= CW'(DEPTH));
    assign ovf_o     = st_q.ovf;
    assign dsc_o     = st_q.dsc;

    // R5: overflow only when every slot was taken and nothing was read
    a_r5_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(st_q.cnt) == CW'(CAP) && !$past(rd_i)));
    // R6: a blocked frame never grows the storage
    a_r6_blocked_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && blk_i) |=> (dsc_o && st_q.cnt <= $past(st_q.cnt)));
    // R10: reading empty storage with no arrival leaves it empty
    a_r10_empty_read_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st_q.cnt == '0 && !frame_i) |=> (st_q.cnt == '0 && rd_data_o == '0));
    // R4: while full, an unblocked frame is still taken when a slot is left
    a_r4_extra_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && !blk_i && !rd_i && st_q.cnt == CW'(DEPTH)) |=> (!ovf_o && st_q.cnt == CW'(CAP)));

endmodule

// File: rtl/serial_buf_status.sv
module serial_buf_status
    import sbs_pkg::*;
#(
    parameter int TX_DEPTH = 2,
    parameter int RX_DEPTH = 2,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_rx_en,
    input  logic                cmd_rx_dis,
    input  logic                cmd_tx_en,
    input  logic                cmd_tx_dis,
    input  logic                cmd_mst_en,
    input  logic                cmd_mst_dis,
    input  logic                cmd_blk_en,
    input  logic                cmd_blk_dis,
    input  logic                cmd_tri_en,
    input  logic                cmd_tri_dis,
    input  logic                tx_wr,
    input  logic                tx_sent,
    input  logic                half_thr,
    input  logic                rx_done,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic                rx_rd,
    output logic [DATA_W-1:0]   rd_data,
    output logic [STATUS_W-1:0] status,
    output logic                rx_ovf,
    output logic                rx_blk_drop
);

    logic [N_FLAGS-1:0] fl_set, fl_clr, fl_q;
    logic tx_level, tx_done, rx_valid, rx_full;

    always_comb begin
        fl_set = '0;
        fl_clr = '0;
        fl_set[FL_RXEN] = cmd_rx_en;
        fl_clr[FL_RXEN] = cmd_rx_dis;
        fl_set[FL_TXEN] = cmd_tx_en;
        fl_clr[FL_TXEN] = cmd_tx_dis;
        fl_set[FL_MST]  = cmd_mst_en;
        fl_clr[FL_MST]  = cmd_mst_dis;
        fl_set[FL_BLK]  = cmd_blk_en;
        fl_clr[FL_BLK]  = cmd_blk_dis;
        fl_set[FL_TRI]  = cmd_tri_en;
        fl_clr[FL_TRI]  = cmd_tri_dis | cmd_tx_en;
    end

    sbs_flag_bank #(.N(N_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fl_set),
        .clr_i  (fl_clr),
        .flag_o (fl_q)
    );

    sbs_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (tx_wr),
        .sent_i  (tx_sent),
        .thr_i   (half_thr),
        .level_o (tx_level),
        .done_o  (tx_done)
    );

    sbs_rx_queue #(.DEPTH(RX_DEPTH), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_i   (rx_done),
        .data_i    (rx_data),
        .blk_i     (fl_q[FL_BLK]),
        .rd_i      (rx_rd),
        .rd_data_o (rd_data),
        .datav_o   (rx_valid),
        .full_o    (rx_full),
        .ovf_o     (rx_ovf),
        .dsc_o     (rx_blk_drop)
    );

    always_comb begin
        status            = '0;
        status[ST_RXEN]   = fl_q[FL_RXEN];
        status[ST_TXEN]   = fl_q[FL_TXEN];
        status[ST_MST]    = fl_q[FL_MST];
        status[ST_BLK]    = fl_q[FL_BLK];
        status[ST_TRI]    = fl_q[FL_TRI];
        status[ST_TXC]    = tx_done;
        status[ST_TXBL]   = tx_level;
        status[ST_DATAV]  = rx_valid;
        status[ST_RXFULL] = rx_full;
    end

    // R12: enabling the transmitter output removes the tristate
    a_r12_txen_clears_tri: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_tx_en |=> !status[ST_TRI]);
    // R3: the storage cannot be full without holding data
    a_r3_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RXFULL] |-> status[ST_DATAV]);
    // R6: blocking drop and overflow never report the same frame
    a_r6_drop_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ovf && rx_blk_drop));

endmodule

// File: tb/tb_serial_buf_status.sv
module tb_serial_buf_status;

    localparam int DW  = 8;
    localparam int TXD = 2;
    localparam int RXD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic c_rxe, c_rxd, c_txe, c_txd, c_me, c_md, c_be, c_bd, c_te, c_td;
    logic tx_wr, tx_sent, half_thr, rx_done, rx_rd;
    logic [DW-1:0] rx_data;
    logic [DW-1:0] rd_data;
    logic [31:0]   status;
    logic          rx_ovf, rx_blk_drop;

    serial_buf_status #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_rx_en(c_rxe), .cmd_rx_dis(c_rxd),
        .cmd_tx_en(c_txe), .cmd_tx_dis(c_txd),
        .cmd_mst_en(c_me), .cmd_mst_dis(c_md),
        .cmd_blk_en(c_be), .cmd_blk_dis(c_bd),
        .cmd_tri_en(c_te), .cmd_tri_dis(c_td),
        .tx_wr(tx_wr), .tx_sent(tx_sent), .half_thr(half_thr),
        .rx_done(rx_done), .rx_data(rx_data), .rx_rd(rx_rd),
        .rd_data(rd_data), .status(status),
        .rx_ovf(rx_ovf), .rx_blk_drop(rx_blk_drop)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int            m_tx = 0;
    bit            m_txc = 0, m_rxe = 0, m_txe = 0, m_mst = 0, m_blk = 0, m_tri = 0;
    bit            m_ovf = 0, m_dsc = 0;
    logic [DW-1:0] m_q[$];

    function automatic bit nxt(bit f, bit s, bit c);
        return c ? 1'b0 : (s ? 1'b1 : f);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx = 0; m_txc = 0; m_rxe = 0; m_txe = 0; m_mst = 0;
            m_blk = 0; m_tri = 0; m_ovf = 0; m_dsc = 0;
            m_q.delete();
        end else begin
            bit acc, pop, blk_old;
            acc = tx_wr && (m_tx < TXD);
            pop = tx_sent && (m_tx > 0);
            m_tx = m_tx + int'(acc) - int'(pop);
            if (tx_wr) m_txc = 0;
            else if (pop && m_tx == 0) m_txc = 1;

            blk_old = m_blk;
            m_ovf = 0;
            m_dsc = 0;
            if (rx_rd && m_q.size() > 0) void'(m_q.pop_front());
            if (rx_done) begin
                if (blk_old) m_dsc = 1;
                else if (m_q.size() < RXD + 1) m_q.push_back(rx_data);
                else m_ovf = 1;
            end

            m_rxe = nxt(m_rxe, c_rxe, c_rxd);
            m_txe = nxt(m_txe, c_txe, c_txd);
            m_mst = nxt(m_mst, c_me, c_md);
            m_blk = nxt(m_blk, c_be, c_bd);
            m_tri = nxt(m_tri, c_te, c_td || c_txe);
        end
    end

    task automatic compare_all();
        bit exp_bl;
        exp_bl = half_thr ? (m_tx <= TXD / 2) : (m_tx == 0);
        chk("R1 upper bits zero", {9'd0, status[31:9]}, 32'd0);
        chk("R3 receive full", status[8], m_q.size() >= RXD);
        chk("R3 receive data valid", status[7], m_q.size() > 0);
        chk("R7 transmit level", status[6], exp_bl);
        chk("R8 transmit complete", status[5], m_txc);
        chk("R12 tristate", status[4], m_tri);
        chk("R11 blocking", status[3], m_blk);
        chk("R11 master", status[2], m_mst);
        chk("R11 tx enable", status[1], m_txe);
        chk("R11 rx enable", status[0], m_rxe);
        chk("R13 read data", rd_data, (m_q.size() > 0) ? m_q[0] : '0);
        chk("R5 overflow pulse", rx_ovf, m_ovf);
        chk("R6 blocked drop pulse", rx_blk_drop, m_dsc);
    endtask

    task automatic quiet();
        {c_rxe, c_rxd, c_txe, c_txd, c_me, c_md, c_be, c_bd, c_te, c_td} = '0;
        tx_wr = 0; tx_sent = 0; rx_done = 0; rx_rd = 0;
    endtask

    // one clock with the currently driven inputs, then compare and go quiet
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    task automatic frame(input logic [DW-1:0] d);
        rx_done = 1; rx_data = d; step();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        quiet();
        half_thr = 0;
        rx_data  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R2 reset status", status, 32'h40);
        compare_all();

        // R11: flag pairs, clear wins on collision
        c_rxe = 1; c_txe = 1; c_me = 1; step();
        chk("R11 flags set", status[2:0], 3'b111);
        c_me = 1; c_md = 1; step();
        chk("R11 master clear wins", status[2], 1'b0);

        // R7 / R9 / R8: transmit side
        tx_wr = 1; step();
        chk("R7 one entry thr0 level", status[6], 1'b0);
        half_thr = 1; @(negedge clk); compare_all();
        chk("R7 one entry thr1 level", status[6], 1'b1);
        tx_wr = 1; step();
        chk("R7 full thr1 level", status[6], 1'b0);
        tx_wr = 1; step();
        tx_sent = 1; step();
        chk("R8 complete not yet", status[5], 1'b0);
        tx_sent = 1; step();
        chk("R9 full write ignored so two retires empty it", status[5], 1'b1);
        tx_sent = 1; step();
        chk("R9 empty retire keeps complete", status[5], 1'b1);
        tx_wr = 1; step();
        chk("R8 write clears complete", status[5], 1'b0);
        tx_sent = 1; tx_wr = 1; step();
        chk("R8 write beats retire", status[5], 1'b0);
        tx_sent = 1; step();
        half_thr = 0;

        // R3 / R4 / R5 / R13: receive side
        frame(8'hA1);
        chk("R3 valid after one", status[8:7], 2'b01);
        frame(8'hA2);
        chk("R3 full at depth", status[8], 1'b1);
        frame(8'hA3);
        chk("R4 shift slot accepted no overflow", rx_ovf, 1'b0);
        frame(8'hA4);
        chk("R5 overflow pulse", rx_ovf, 1'b1);
        step();
        chk("R5 overflow pulse one cycle", rx_ovf, 1'b0);
        chk("R13 oldest first", rd_data, 8'hA1);
        rx_rd = 1; rx_done = 1; rx_data = 8'hA5; step();
        chk("R13 read with arrival", rd_data, 8'hA2);
        rx_rd = 1; step();
        chk("R4 shift slot frame readable", rd_data, 8'hA3);
        rx_rd = 1; step();
        rx_rd = 1; step();
        chk("R3 empty after drain", status[8:7], 2'b00);
        rx_rd = 1; step();
        chk("R10 empty read returns zero", rd_data, 8'h00);
        frame(8'h5C);
        chk("R10 storage unchanged by empty read", rd_data, 8'h5C);
        rx_rd = 1; step();

        // R6: blocking sampled before the edge
        c_be = 1; rx_done = 1; rx_data = 8'h77; step();
        chk("R6 same-cycle block command not applied", rd_data, 8'h77);
        frame(8'h78);
        chk("R6 blocked frame pulse", rx_blk_drop, 1'b1);
        chk("R6 blocked frame not stored", status[8], 1'b0);
        c_bd = 1; step();
        rx_rd = 1; step();

        // R12: tristate
        c_te = 1; step();
        chk("R12 tristate set", status[4], 1'b1);
        c_txe = 1; step();
        chk("R12 tx enable clears tristate", status[4], 1'b0);
        c_te = 1; c_td = 1; step();
        chk("R12 clear wins", status[4], 1'b0);

        // random phase, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            c_rxe = ($urandom % 16) == 0; c_rxd = ($urandom % 16) == 0;
            c_txe = ($urandom % 16) == 0; c_txd = ($urandom % 16) == 0;
            c_me  = ($urandom % 16) == 0; c_md  = ($urandom % 16) == 0;
            c_be  = ($urandom % 12) == 0; c_bd  = ($urandom % 6) == 0;
            c_te  = ($urandom % 10) == 0; c_td  = ($urandom % 16) == 0;
            tx_wr   = ($urandom % 3) == 0;
            tx_sent = ($urandom % 3) == 0;
            rx_done = ($urandom % 2) == 0;
            rx_rd   = ($urandom % 3) == 0;
            rx_data = DW'($urandom);
            if (($urandom % 8) == 0) half_thr = ~half_thr;
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule